// File: doc/BRIEF.md
# Parallel Port Control-Line Handshake Logic

This block handles the two control lines that go with one 8-bit parallel port. The first line is an input only. The second line can be an interrupt input or an output. A 4-bit control nibble selects the edge of the first line and one of eight modes for the second line. The block finds active edges on both lines and presents them as one-cycle flag-set requests. It turns port-register strobes and explicit clear strobes from the bus decoder into flag-clear requests. When the second line is an output, it drives the line and its output enable.

All inputs are sampled only in cycles where `clk_en` is high. The interrupt flag registers sit outside this block and take the set and clear requests it produces. The block has two port-register strobes. `data_acc` is a read or write of the handshaking port data register. `alias_acc` is an access to the alias of that register that carries no handshake.

Top module: `hsk_ctl_lines`

## Requirements
- R1: Nibble bit 0 selects the active edge of `c1_in`: 1 means rising and 0 means falling. An active edge raises `c1_evt` combinationally in the enabled cycle where `c1_in` differs from its last enabled sample. The opposite edge raises nothing.
- R2: Both lines are sampled only when `clk_en` is 1. An edge that appears while `clk_en` is 0 raises no event during that time. The edge is reported in the first cycle where `clk_en` is 1.
- R3: In modes 0 and 2 (nibble bits 3:1 = 000 or 010), `c2_in` is an input. Mode 0 reports falling edges and mode 2 reports rising edges on `c2_evt`. An enabled `data_acc` also raises `c2_clr_req`.
- R4: In modes 1 and 3 (001 = falling edge, 011 = rising edge), `data_acc` does not raise `c2_clr_req`. Only `c2_clr` raises it.
- R5: `c1_clr_req` is raised in an enabled cycle that has `data_acc` or `c1_clr`.
- R6: `alias_acc` has no effect: it raises no clear request and does not change `c2_out`.
- R7: In modes 4 to 7 (nibble bit 3 = 1), `c2_evt` stays 0. `c2_oe` is 1 from the enabled edge after such a mode is chosen, and 0 after an input mode is chosen.
- R8: In mode 4, an enabled `data_acc` drives `c2_out` low from the next edge. The line then stays low until an active `c1_in` edge drives it high at the next edge. If both happen in the same cycle, the access wins.
- R9: In mode 5, `c2_out` is low for exactly one enabled cycle after an enabled `data_acc`.
- R10: Mode 6 drives `c2_out` low and mode 7 drives it high, from the next enabled edge.
- R11: After reset, `c2_out` is 1, `c2_oe` is 0 and no event or clear request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Qualifies every sample and register update |
| ctl_nib | input | 4 | Bit 0: edge of line 1; bits 3:1: mode of line 2 |
| c1_in | input | 1 | First control line (input only) |
| c2_in | input | 1 | Second control line, as seen at the pin |
| data_acc | input | 1 | Read or write strobe of the handshaking port data register |
| alias_acc | input | 1 | Strobe of the non-handshake alias register |
| c1_clr | input | 1 | Explicit clear strobe for the line-1 flag |
| c2_clr | input | 1 | Explicit clear strobe for the line-2 flag |
| c1_evt | output | 1 | Set request for the line-1 flag |
| c2_evt | output | 1 | Set request for the line-2 flag |
| c1_clr_req | output | 1 | Clear request for the line-1 flag |
| c2_clr_req | output | 1 | Clear request for the line-2 flag |
| c2_out | output | 1 | Level driven on line 2 |
| c2_oe | output | 1 | Output enable for line 2 |

## Verification
The hardest state to reach is the mode-4 handshake. It needs three things in order: a port access that drops the line, a spell where alias accesses and idle cycles must leave the line low, and then an active edge on the first line that raises it again. The bench builds this sequence directly. It samples `c2_out` after every step, so both the drop and the restore are pinned to one exact edge. A separate sequence holds `clk_en` low while an edge arrives. This shows that the edge is deferred, not lost.

// File: rtl/hsk_ctl_pkg.sv
package hsk_ctl_pkg;
  localparam int NIB_W  = 4;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_IN_FALL_CLR  = 3'd0,
    M_IN_FALL_IND  = 3'd1,
    M_IN_RISE_CLR  = 3'd2,
    M_IN_RISE_IND  = 3'd3,
    M_OUT_HANDSHK  = 3'd4,
    M_OUT_PULSE    = 3'd5,
    M_OUT_LOW      = 3'd6,
    M_OUT_HIGH     = 3'd7
  } c2_mode_e;

  function automatic logic edge_hit(input logic prev, input logic cur, input logic rising);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction

  function automatic logic is_output_mode(input c2_mode_e m);
    return m[MODE_W-1];
  endfunction

  function automatic logic c2_rising(input c2_mode_e m);
    return m[1];
  endfunction

  function automatic logic access_clears(input c2_mode_e m);
    return ~m[MODE_W-1] & ~m[0];
  endfunction

  function automatic logic c2_next(input c2_mode_e m, input logic acc,
                                   input logic restore, input logic cur);
    case (m)
      M_OUT_HANDSHK: return acc ? 1'b0 : (restore ? 1'b1 : cur);
      M_OUT_PULSE:   return ~acc;
      M_OUT_LOW:     return 1'b0;
      default:       return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/hsk_edge_det.sv
module hsk_edge_det #(
  parameter logic PREV_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  input  logic rising,
  output logic hit
);
  import hsk_ctl_pkg::*;

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prev_q <= PREV_INIT;
    else if (en) prev_q <= din;
  end

  assign hit = en & edge_hit(prev_q, din, rising);
endmodule

// File: rtl/hsk_line2_drv.sv
module hsk_line2_drv
  import hsk_ctl_pkg::*;
#(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  c2_mode_e mode,
  input  logic     acc,
  input  logic     restore,
  output logic     line_out,
  output logic     line_oe
);
  logic out_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= IDLE_LEVEL;
      oe_q  <= 1'b0;
    end else if (en) begin
      out_q <= c2_next(mode, acc, restore, out_q);
      oe_q  <= is_output_mode(mode);
    end
  end

  assign line_out = out_q;
  assign line_oe  = oe_q;
endmodule

// File: rtl/hsk_ctl_lines.sv
module hsk_ctl_lines
  import hsk_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [NIB_W-1:0] ctl_nib,
  input  logic             c1_in,
  input  logic             c2_in,
  input  logic             data_acc,
  input  logic             alias_acc,
  input  logic             c1_clr,
  input  logic             c2_clr,
  output logic             c1_evt,
  output logic             c2_evt,
  output logic             c1_clr_req,
  output logic             c2_clr_req,
  output logic             c2_out,
  output logic             c2_oe
);
  c2_mode_e mode;
  logic     c1_hit, c2_hit, acc_en;
  logic     alias_seen;

  assign mode       = c2_mode_e'(ctl_nib[NIB_W-1:1]);
  assign acc_en     = clk_en & data_acc;
  assign alias_seen = clk_en & alias_acc;

  hsk_edge_det u_c1_det (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .din(c1_in),
    .rising(ctl_nib[0]), .hit(c1_hit)
  );

  hsk_edge_det u_c2_det (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .din(c2_in),
    .rising(c2_rising(mode)), .hit(c2_hit)
  );

  hsk_line2_drv u_drv (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .mode(mode),
    .acc(data_acc), .restore(c1_hit),
    .line_out(c2_out), .line_oe(c2_oe)
  );

  assign c1_evt     = c1_hit;
  assign c2_evt     = c2_hit & ~is_output_mode(mode);
  assign c1_clr_req = clk_en & (data_acc | c1_clr);
  assign c2_clr_req = clk_en & (c2_clr | (data_acc & access_clears(mode)));
endmodule

// File: rtl/hsk_ctl_lines_chk.sv
module hsk_ctl_lines_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en,
  input logic [3:0] ctl_nib,
  input logic       data_acc,
  input logic       alias_acc,
  input logic       c1_clr,
  input logic       c2_clr,
  input logic       c1_evt,
  input logic       c2_evt,
  input logic       c1_clr_req,
  input logic       c2_clr_req,
  input logic       c2_out,
  input logic       c2_oe,
  input logic       alias_seen
);
  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !c2_oe |-> c2_out);

  assert_no_evt_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> (!c1_evt && !c2_evt && !c1_clr_req && !c2_clr_req));

  assert_no_out_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_nib[3] |-> !c2_evt);

  assert_alias_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alias_seen && !data_acc && !c1_clr && !c2_clr) |-> (!c1_clr_req && !c2_clr_req));

  assert_ind_no_acc_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_nib[3:2] == 2'b00 && ctl_nib[1] && !c2_clr) |-> !c2_clr_req);

  assert_pulse_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && ctl_nib[3:1] == 3'd5 && data_acc) |=> !c2_out);

  assert_force_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && ctl_nib[3:1] == 3'd7) |=> (c2_out && c2_oe));

  assert_force_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && ctl_nib[3:1] == 3'd6) |=> (!c2_out && c2_oe));

  assert_acc_clr1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && data_acc) |-> c1_clr_req);
endmodule

bind hsk_ctl_lines hsk_ctl_lines_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ctl_nib(ctl_nib),
  .data_acc(data_acc), .alias_acc(alias_acc), .c1_clr(c1_clr), .c2_clr(c2_clr),
  .c1_evt(c1_evt), .c2_evt(c2_evt), .c1_clr_req(c1_clr_req),
  .c2_clr_req(c2_clr_req), .c2_out(c2_out), .c2_oe(c2_oe),
  .alias_seen(alias_seen)
);

// File: tb/hsk_ctl_lines_test.sv
module hsk_ctl_lines_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic [3:0] ctl_nib = 4'd0;
  logic       c1_in = 1'b0, c2_in = 1'b0;
  logic       data_acc = 1'b0, alias_acc = 1'b0, c1_clr = 1'b0, c2_clr = 1'b0;
  logic       c1_evt, c2_evt, c1_clr_req, c2_clr_req, c2_out, c2_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hsk_ctl_lines uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ctl_nib(ctl_nib),
    .c1_in(c1_in), .c2_in(c2_in), .data_acc(data_acc), .alias_acc(alias_acc),
    .c1_clr(c1_clr), .c2_clr(c2_clr), .c1_evt(c1_evt), .c2_evt(c2_evt),
    .c1_clr_req(c1_clr_req), .c2_clr_req(c2_clr_req),
    .c2_out(c2_out), .c2_oe(c2_oe)
  );

  // vector: nib[13:10] c1 c2 acc alias clr1 clr2 | exp e1 e2 r1 r2
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {4'b0001, 6'b100000, 4'b1000}, // R1 rising line1
    {4'b0001, 6'b110000, 4'b0000}, // R3 rising ignored in mode 0
    {4'b0001, 6'b100000, 4'b0100}, // R3 falling in mode 0
    {4'b0001, 6'b101000, 4'b0011}, // R3 R5 access clears both
    {4'b0011, 6'b101000, 4'b0010}, // R4 mode 1 access keeps flag 2
    {4'b0011, 6'b100100, 4'b0000}, // R6 alias does nothing
    {4'b0011, 6'b100001, 4'b0001}, // R4 explicit clear
    {4'b0101, 6'b110000, 4'b0100}, // R3 mode 2 rising
    {4'b0101, 6'b111000, 4'b0011}, // R3 mode 2 access clears
    {4'b0111, 6'b101000, 4'b0010}, // R4 mode 3 falling ignored, no clear
    {4'b0111, 6'b110000, 4'b0100}, // R4 mode 3 rising
    {4'b0000, 6'b010010, 4'b1010}, // R1 falling line1, R5 explicit clear
    {4'b1000, 6'b000000, 4'b0000}  // R7 no line2 event in output mode
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_line(input string req, input logic o, input logic oe);
    chk(req, {2'b00, c2_out, c2_oe}, {2'b00, o, oe});
  endtask

  task automatic nxt;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) nxt();
    #1;
    chk("R11 reset", {c1_evt, c2_evt, c1_clr_req, c2_clr_req}, 4'b0000);
    chk_line("R11 reset line", 1'b1, 1'b0);
    rst_n = 1'b1;
    nxt();

    // R2: edge while disabled is held off
    ctl_nib = 4'b0001; clk_en = 1'b0; c1_in = 1'b1;
    #1 chk("R2 gated", {c1_evt, c2_evt, 2'b00}, 4'b0000);
    nxt(); #1 chk("R2 still gated", {c1_evt, c2_evt, 2'b00}, 4'b0000);
    clk_en = 1'b1;
    #1 chk("R2 deferred edge", {c1_evt, c2_evt, 2'b00}, 4'b1000);
    nxt();
    c1_in = 1'b0; nxt();

    for (int i = 0; i < NV; i++) begin
      {ctl_nib, c1_in, c2_in, data_acc, alias_acc, c1_clr, c2_clr} = VEC[i][13:4];
      #1 chk($sformatf("vector %0d", i), {c1_evt, c2_evt, c1_clr_req, c2_clr_req}, VEC[i][3:0]);
      nxt();
    end
    data_acc = 1'b0; c1_clr = 1'b0; c2_clr = 1'b0;

    // R8 handshake, line1 rising edge restores
    ctl_nib = 4'b1001; c1_in = 1'b0; nxt();
    #1 chk_line("R7 oe on in mode 4", 1'b1, 1'b1);
    data_acc = 1'b1; nxt(); data_acc = 1'b0;
    #1 chk_line("R8 drop on access", 1'b0, 1'b1);
    alias_acc = 1'b1; nxt(); alias_acc = 1'b0; nxt();
    #1 chk_line("R6 alias keeps low", 1'b0, 1'b1);
    c1_in = 1'b1; nxt();
    #1 chk_line("R8 restore on edge", 1'b1, 1'b1);
    c1_in = 1'b0; data_acc = 1'b1; nxt(); data_acc = 1'b0;
    c1_in = 1'b1; data_acc = 1'b1; nxt(); data_acc = 1'b0;
    #1 chk_line("R8 access wins over edge", 1'b0, 1'b1);
    nxt();

    // R9 pulse
    ctl_nib = 4'b1010; nxt();
    #1 chk_line("R9 idle high", 1'b1, 1'b1);
    data_acc = 1'b1; nxt(); data_acc = 1'b0;
    #1 chk_line("R9 low one cycle", 1'b0, 1'b1);
    nxt(); #1 chk_line("R9 back high", 1'b1, 1'b1);
    alias_acc = 1'b1; nxt(); alias_acc = 1'b0;
    #1 chk_line("R6 alias no pulse", 1'b1, 1'b1);

    // R10 forced levels
    ctl_nib = 4'b1100; nxt();
    #1 chk_line("R10 forced low", 1'b0, 1'b1);
    ctl_nib = 4'b1110; nxt();
    #1 chk_line("R10 forced high", 1'b1, 1'b1);
    ctl_nib = 4'b1100; nxt();
    ctl_nib = 4'b0000; nxt();
    #1 chk_line("R7 back to input", 1'b1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule